// File: doc/BRIEF.md
# SPI Command Engine Host Register Block

This block is the software-facing register slave of a command-driven SPI master. A host reaches it through a simple valid/ready register port. It uses it to push 16-bit command words and 8-bit transmit bytes into two queues, and to drain received bytes from a third queue. The shifting engine sits on the other side of those queues and is reached only through per-queue valid/ready handshakes. The engine also reports the completion of a sync command through a one-cycle strobe that carries an 8-bit tag.

Software learns the state of each queue as a count: free slots for the command and transmit queues, and stored entries for the receive queue. The receive queue can be read destructively or inspected through a peek address that leaves it unchanged. Four interrupt causes feed one interrupt line through an enable mask. Three of them are level conditions set by queue watermarks. The fourth latches when a sync strobe arrives and stays set until software clears it. A soft-reset register holds the engine in reset until software releases it.

Top module: `spi_host_regs`

## Requirements
- R1: A read of address 0x00 returns {8'h00, major=8'd1, VER_MINOR, VER_PATCH}.
- R2: Bit 0 of the register at 0x40 drives `engine_rst_o`. It is 1 after reset, is loaded from wdata[0] on a write, and reads back in bit 0.
- R3: A write to 0xE0 appends wdata[15:0] to the command queue, unless the queue already holds CMD_DEPTH entries, in which case the write is dropped. The entries leave first-in first-out on `cmd_data_o` while `cmd_valid_o` is high, and one entry is removed on each cycle in which `cmd_ready_i` is high.
- R4: A write to 0xE4 appends wdata[7:0] to the transmit queue, with the same drop-when-full rule and first-in first-out handshake on the `tx_*` ports.
- R5: A read of 0xD0 returns CMD_DEPTH minus the command entries, 0xD4 returns TX_DEPTH minus the transmit entries, and 0xD8 returns the receive entries. Each count is the value before the read's clock edge.
- R6: A read of 0xE8 returns the oldest receive byte zero-extended and removes it. When the queue is empty, the read returns 0 and removes nothing.
- R7: A read of 0xEC returns the oldest receive byte, or 0 when the queue is empty, and leaves the queue unchanged.
- R8: A cycle with `sync_valid_i` high stores `sync_id_i`, which a read of 0xC0 then returns, and sets pending bit 3. In the same cycle, the set takes priority over a clear.
- R9: Pending bits 0 (command entries <= CMD_LOW_MARK), 1 (transmit entries <= TX_LOW_MARK) and 2 (receive entries >= RX_HIGH_MARK) are set one cycle after their condition holds and stay set while it holds. Writing 1 to a bit at 0x84 clears it. A read of 0x84 returns the pending bits.
- R10: The register at 0x80 holds the enable mask in bits 3:0. A read of 0x88 returns pending AND enable, and `irq_o` is high exactly when that value is nonzero.
- R11: `req_ready_o` is always 1. Each read request produces `rsp_valid_o` for exactly one cycle on the next cycle. Writes produce no response. Unmapped reads return 0.
- R12: `rx_ready_o` is low while the receive queue holds RX_DEPTH entries. A byte offered on `rx_valid_i` while the queue is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| cmd_valid_o | output | 1 | Command queue not empty |
| cmd_data_o | output | 16 | Oldest command word |
| cmd_ready_i | input | 1 | Engine takes the command word |
| tx_valid_o | output | 1 | Transmit queue not empty |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_ready_i | input | 1 | Engine takes the transmit byte |
| rx_valid_i | input | 1 | Engine offers a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_ready_o | output | 1 | Receive queue has room |
| sync_valid_i | input | 1 | Sync completion strobe |
| sync_id_i | input | 8 | Tag of the completed sync |
| engine_rst_o | output | 1 | Holds the engine in reset |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data and `rsp_valid_o` appear one cycle after the request edge. Queue outputs and `rx_ready_o` change at the edge that pushes or pops. Pending bits lag their watermark condition by one edge, and `irq_o` follows the pending bits with no further delay. The bench models this timing with queues and integers that it updates on the rising edge. It then compares every output against the model on the falling edge that follows, so each result is checked in the first cycle in which it is due and in every cycle after.

// File: rtl/spi_host_regs_pkg.sv
package spi_host_regs_pkg;
  localparam logic [7:0] ADDR_VERSION  = 8'h00;
  localparam logic [7:0] ADDR_ENG_RST  = 8'h40;
  localparam logic [7:0] ADDR_IRQ_EN   = 8'h80;
  localparam logic [7:0] ADDR_IRQ_PEND = 8'h84;
  localparam logic [7:0] ADDR_IRQ_SRC  = 8'h88;
  localparam logic [7:0] ADDR_SYNC_TAG = 8'hC0;
  localparam logic [7:0] ADDR_CMD_ROOM = 8'hD0;
  localparam logic [7:0] ADDR_TX_ROOM  = 8'hD4;
  localparam logic [7:0] ADDR_RX_LVL   = 8'hD8;
  localparam logic [7:0] ADDR_CMD_PUSH = 8'hE0;
  localparam logic [7:0] ADDR_TX_PUSH  = 8'hE4;
  localparam logic [7:0] ADDR_RX_POP   = 8'hE8;
  localparam logic [7:0] ADDR_RX_PEEK  = 8'hEC;

  localparam int IRQ_W       = 4;
  localparam int IRQ_CMD_LOW = 0;
  localparam int IRQ_TX_LOW  = 1;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_SYNC    = 3;

  localparam int CMD_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [7:0] VER_MAJOR = 8'd1;
endpackage

// File: rtl/shq_fifo.sv
module shq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign data_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R3 R4 R12: a push into a full queue is dropped
  a_r12_full_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (count_o == CW'(DEPTH)));
  // R6: a pop from an empty queue leaves it empty
  a_r6_empty_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
  a_r3_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
endmodule

// File: rtl/shq_irq_ctrl.sv
module shq_irq_ctrl
  import spi_host_regs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cond_i,
  input  logic             sync_i,
  input  logic [IRQ_W-1:0] clr_i,
  input  logic             en_we_i,
  input  logic [IRQ_W-1:0] en_i,
  output logic [IRQ_W-1:0] pend_o,
  output logic [IRQ_W-1:0] en_o,
  output logic [IRQ_W-1:0] src_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] pend_q, en_q, pend_d;

  always_comb begin
    pend_d = pend_q & ~clr_i;
    pend_d[IRQ_RX_HIGH:IRQ_CMD_LOW] = pend_d[IRQ_RX_HIGH:IRQ_CMD_LOW] | cond_i;
    if (sync_i) pend_d[IRQ_SYNC] = 1'b1;  // set beats clear
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_we_i) en_q <= en_i;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign src_o  = pend_q & en_q;
  assign irq_o  = |src_o;

  a_r9_cond_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cond_i) |=> ((pend_o[2:0] & $past(cond_i)) == $past(cond_i)));
  a_r8_sync_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> pend_o[IRQ_SYNC]);
  a_r9_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i[IRQ_SYNC] && !sync_i) |=> !pend_o[IRQ_SYNC]);
  a_r10_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o == '0) |-> !irq_o);
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_regs_pkg::*;
#(
  parameter int unsigned CMD_DEPTH    = 16,
  parameter int unsigned TX_DEPTH     = 16,
  parameter int unsigned RX_DEPTH     = 16,
  parameter int unsigned CMD_LOW_MARK = 2,
  parameter int unsigned TX_LOW_MARK  = 2,
  parameter int unsigned RX_HIGH_MARK = 12,
  parameter logic [7:0]  VER_MINOR    = 8'd0,
  parameter logic [7:0]  VER_PATCH    = 8'h61
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [7:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        cmd_valid_o,
  output logic [15:0] cmd_data_o,
  input  logic        cmd_ready_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_ready_i,
  input  logic        rx_valid_i,
  input  logic [7:0]  rx_data_i,
  output logic        rx_ready_o,
  input  logic        sync_valid_i,
  input  logic [7:0]  sync_id_i,
  output logic        engine_rst_o,
  output logic        irq_o
);
  localparam int CMD_CW = $clog2(CMD_DEPTH + 1);
  localparam int TX_CW  = $clog2(TX_DEPTH + 1);
  localparam int RX_CW  = $clog2(RX_DEPTH + 1);

  logic wr_en, rd_en;
  assign req_ready_o = 1'b1;
  assign wr_en = req_valid_i && req_write_i;
  assign rd_en = req_valid_i && !req_write_i;

  logic [CMD_CW-1:0] cmd_cnt;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic [BYTE_W-1:0] rx_head;
  logic cmd_empty, tx_empty, rx_empty, cmd_full, tx_full, rx_full;

  shq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk_i, .rst_ni,
    .push_i (wr_en && req_addr_i == ADDR_CMD_PUSH),
    .data_i (req_wdata_i[CMD_W-1:0]),
    .pop_i  (cmd_ready_i),
    .data_o (cmd_data_o), .count_o(cmd_cnt),
    .full_o (cmd_full),   .empty_o(cmd_empty));

  shq_fifo #(.W(BYTE_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk_i, .rst_ni,
    .push_i (wr_en && req_addr_i == ADDR_TX_PUSH),
    .data_i (req_wdata_i[BYTE_W-1:0]),
    .pop_i  (tx_ready_i),
    .data_o (tx_data_o), .count_o(tx_cnt),
    .full_o (tx_full),   .empty_o(tx_empty));

  shq_fifo #(.W(BYTE_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk_i, .rst_ni,
    .push_i (rx_valid_i),
    .data_i (rx_data_i),
    .pop_i  (rd_en && req_addr_i == ADDR_RX_POP),
    .data_o (rx_head), .count_o(rx_cnt),
    .full_o (rx_full), .empty_o(rx_empty));

  assign cmd_valid_o = !cmd_empty;
  assign tx_valid_o  = !tx_empty;
  assign rx_ready_o  = !rx_full;

  logic unused_bits;
  assign unused_bits = ^{req_wdata_i[31:CMD_W], cmd_full, tx_full};

  logic [2:0]       wm_cond;
  logic [IRQ_W-1:0] pend, en, src;
  assign wm_cond[IRQ_CMD_LOW] = 32'(cmd_cnt) <= CMD_LOW_MARK;
  assign wm_cond[IRQ_TX_LOW]  = 32'(tx_cnt)  <= TX_LOW_MARK;
  assign wm_cond[IRQ_RX_HIGH] = 32'(rx_cnt)  >= RX_HIGH_MARK;

  shq_irq_ctrl u_irq (
    .clk_i, .rst_ni,
    .cond_i  (wm_cond),
    .sync_i  (sync_valid_i),
    .clr_i   ((wr_en && req_addr_i == ADDR_IRQ_PEND) ? req_wdata_i[IRQ_W-1:0] : '0),
    .en_we_i (wr_en && req_addr_i == ADDR_IRQ_EN),
    .en_i    (req_wdata_i[IRQ_W-1:0]),
    .pend_o  (pend), .en_o(en), .src_o(src),
    .irq_o   (irq_o));

  logic       eng_rst_q;
  logic [7:0] sync_tag_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eng_rst_q  <= 1'b1;
      sync_tag_q <= '0;
    end else begin
      if (wr_en && req_addr_i == ADDR_ENG_RST) eng_rst_q <= req_wdata_i[0];
      if (sync_valid_i) sync_tag_q <= sync_id_i;
    end
  end
  assign engine_rst_o = eng_rst_q;

  logic [31:0] rd_d;
  always_comb begin
    rd_d = '0;
    unique case (req_addr_i)
      ADDR_VERSION:  rd_d = {8'h00, VER_MAJOR, VER_MINOR, VER_PATCH};
      ADDR_ENG_RST:  rd_d = 32'(eng_rst_q);
      ADDR_IRQ_EN:   rd_d = 32'(en);
      ADDR_IRQ_PEND: rd_d = 32'(pend);
      ADDR_IRQ_SRC:  rd_d = 32'(src);
      ADDR_SYNC_TAG: rd_d = 32'(sync_tag_q);
      ADDR_CMD_ROOM: rd_d = CMD_DEPTH - 32'(cmd_cnt);
      ADDR_TX_ROOM:  rd_d = TX_DEPTH - 32'(tx_cnt);
      ADDR_RX_LVL:   rd_d = 32'(rx_cnt);
      ADDR_RX_POP, ADDR_RX_PEEK: rd_d = rx_empty ? '0 : 32'(rx_head);
      default:       rd_d = '0;
    endcase
  end

  logic        rsp_valid_q;
  logic [31:0] rsp_rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
    end else begin
      rsp_valid_q <= rd_en;
      if (rd_en) rsp_rdata_q <= rd_d;
    end
  end
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_rdata_q;

  a_r11_read_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en |=> rsp_valid_o);
  a_r11_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> !rsp_valid_o);
  a_r2_rst_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && req_addr_i == ADDR_ENG_RST) |=> (engine_rst_o == $past(req_wdata_i[0])));
  a_r8_tag_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_valid_i |=> (sync_tag_q == $past(sync_id_i)));
endmodule

// File: tb/spi_host_regs_test.sv
module spi_host_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int CD = 4, TD = 4, RD = 4;
  localparam int CLO = 1, TLO = 1, RHI = 3;
  localparam logic [7:0] MINOR = 8'd2, PATCH = 8'h63;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic cmd_ready = 0, tx_ready = 0, rx_valid = 0, sync_valid = 0;
  logic [7:0] rx_data = 0, sync_id = 0;
  logic req_ready, rsp_valid, cmd_valid, tx_valid, rx_ready, eng_rst, irq;
  logic [31:0] rsp_rdata;
  logic [15:0] cmd_data;
  logic [7:0] tx_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_host_regs #(.CMD_DEPTH(CD), .TX_DEPTH(TD), .RX_DEPTH(RD),
    .CMD_LOW_MARK(CLO), .TX_LOW_MARK(TLO), .RX_HIGH_MARK(RHI),
    .VER_MINOR(MINOR), .VER_PATCH(PATCH)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .cmd_valid_o(cmd_valid), .cmd_data_o(cmd_data), .cmd_ready_i(cmd_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_ready_o(rx_ready),
    .sync_valid_i(sync_valid), .sync_id_i(sync_id),
    .engine_rst_o(eng_rst), .irq_o(irq));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  logic [15:0] cmd_q[$];
  logic [7:0]  tx_q[$], rx_q[$];
  logic [3:0]  m_pend, m_en, m_cond, m_clr;
  logic [7:0]  m_id;
  logic        m_rst, m_rv;
  logic [31:0] m_rd;
  string       m_tag;

  function automatic logic [31:0] mread(logic [7:0] a);
    case (a)
      8'h00: return {8'h00, 8'd1, MINOR, PATCH};
      8'h40: return 32'(m_rst);
      8'h80: return 32'(m_en);
      8'h84: return 32'(m_pend);
      8'h88: return 32'(m_pend & m_en);
      8'hC0: return 32'(m_id);
      8'hD0: return CD - cmd_q.size();
      8'hD4: return TD - tx_q.size();
      8'hD8: return rx_q.size();
      8'hE8, 8'hEC: return (rx_q.size() == 0) ? 32'h0 : 32'(rx_q[0]);
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rtag(logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h40: return "R2";
      8'h80, 8'h88: return "R10";
      8'h84: return "R9";
      8'hC0: return "R8";
      8'hD0, 8'hD4, 8'hD8: return "R5";
      8'hE8: return "R6";
      8'hEC: return "R7";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q.delete(); tx_q.delete(); rx_q.delete();
      m_pend = 0; m_en = 0; m_id = 0; m_rst = 1; m_rv = 0; m_rd = 0; m_tag = "R11";
    end else begin
      m_cond = {1'b0, rx_q.size() >= RHI, tx_q.size() <= TLO, cmd_q.size() <= CLO};
      m_rv = req_valid && !req_write;
      if (m_rv) begin m_rd = mread(req_addr); m_tag = rtag(req_addr); end
      m_clr = (req_valid && req_write && req_addr == 8'h84) ? req_wdata[3:0] : 4'h0;
      m_pend = (m_pend & ~m_clr) | m_cond;
      if (sync_valid) begin m_pend[3] = 1'b1; m_id = sync_id; end
      if (req_valid && req_write && req_addr == 8'h80) m_en = req_wdata[3:0];
      if (req_valid && req_write && req_addr == 8'h40) m_rst = req_wdata[0];
      begin
        bit cpush, tpush, rpush;
        cpush = req_valid && req_write && req_addr == 8'hE0 && cmd_q.size() < CD;
        tpush = req_valid && req_write && req_addr == 8'hE4 && tx_q.size() < TD;
        rpush = rx_valid && rx_q.size() < RD;
        if (cmd_ready && cmd_q.size() > 0) void'(cmd_q.pop_front());
        if (tx_ready && tx_q.size() > 0) void'(tx_q.pop_front());
        if (req_valid && !req_write && req_addr == 8'hE8 && rx_q.size() > 0) void'(rx_q.pop_front());
        if (cpush) cmd_q.push_back(req_wdata[15:0]);
        if (tpush) tx_q.push_back(req_wdata[7:0]);
        if (rpush) rx_q.push_back(rx_data);
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R11", "req_ready", 32'(req_ready), 32'd1);
    chk("R2",  "engine_rst", 32'(eng_rst), 32'(m_rst));
    chk("R10", "irq", 32'(irq), 32'(|(m_pend & m_en)));
    chk("R3",  "cmd_valid", 32'(cmd_valid), 32'(cmd_q.size() > 0));
    if (cmd_q.size() > 0) chk("R3", "cmd_data", 32'(cmd_data), 32'(cmd_q[0]));
    chk("R4",  "tx_valid", 32'(tx_valid), 32'(tx_q.size() > 0));
    if (tx_q.size() > 0) chk("R4", "tx_data", 32'(tx_data), 32'(tx_q[0]));
    chk("R12", "rx_ready", 32'(rx_ready), 32'(rx_q.size() < RD));
    chk("R11", "rsp_valid", 32'(rsp_valid), 32'(m_rv));
    if (m_rv) chk(m_tag, "rsp_rdata", rsp_rdata, m_rd);
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
  endtask
  task automatic rd(logic [7:0] a);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1;
    idle(3);
    rd(8'h00);                      // R1
    rd(8'h40); wr(8'h40, 0); rd(8'h40);   // R2
    rd(8'h10); rd(8'h84);           // R11 unmapped, R9 watermarks after reset
    wr(8'h80, 32'hF); rd(8'h80); rd(8'h88);  // R10
    for (int i = 0; i < 6; i++) wr(8'hE0, 32'hABC0_1230 + i);  // R3 overfill
    rd(8'hD0);
    for (int i = 0; i < 6; i++) wr(8'hE4, 32'h0000_5A40 + i);  // R4 overfill
    rd(8'hD4);
    wr(8'h84, 32'h3); rd(8'h84);    // R9 W1C of cleared conditions
    @(negedge clk) cmd_ready = 1; tx_ready = 1;
    idle(6);
    @(negedge clk) cmd_ready = 0; tx_ready = 0;
    rd(8'h84);                      // R9 reasserted
    rd(8'hE8); rd(8'hEC);           // R6 R7 empty
    for (int i = 0; i < 6; i++) begin  // R12 overfill
      @(negedge clk) rx_valid = 1; rx_data = 8'hA0 + 8'(i);
    end
    @(negedge clk) rx_valid = 0;
    rd(8'hD8); rd(8'h84); rd(8'hEC); rd(8'hEC);
    for (int i = 0; i < 5; i++) rd(8'hE8);
    rd(8'hD8);
    wr(8'h80, 32'h8);
    @(negedge clk) sync_valid = 1; sync_id = 8'h5A;  // R8
    @(negedge clk) sync_valid = 0;
    rd(8'hC0); rd(8'h88);
    @(negedge clk) sync_valid = 1; sync_id = 8'h3C;
    req_valid = 1; req_write = 1; req_addr = 8'h84; req_wdata = 32'hFF;
    @(negedge clk) sync_valid = 0; req_valid = 0;
    rd(8'h84); rd(8'hC0);
    wr(8'h84, 32'hFF); rd(8'h84); rd(8'h88);
    wr(8'h40, 1); rd(8'h40);
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule